// File: doc/BRIEF.md
# Receiver Status Flag Register with Guarded Clear

This block holds eight sticky status flags for the receive side of a CAN-style controller. Hardware event pulses set the flags. Each flag then stays set until software clears it by writing a one to its bit position. Alongside the flags sits an eight-bit enable register. A single interrupt request is raised whenever any flag is set while its enable bit is also set.

A clear is honoured only when the cause behind the flag has gone away. For each flag the protocol engine supplies a level input that says whether that cause is still present. A write of one to a bit is refused while that level is high, so a flag cannot be dismissed too early. The wake-up flag has no separate level input. Its cause is bus activity seen while the controller is asleep, so that same condition both sets it and blocks its clear.

The block has two resets. An asynchronous hard reset clears both registers. A synchronous soft reset clears only the flags and leaves the enable register as it was.

Top module: `rxStatusFlags`

## Requirements
- R1: While the hard reset `rstN` is low, `flagRd` and `enableRd` are 0 and `irqReq` is low.
- R2: A one on `eventIn[k]` (k = 0..6) sets `flagRd[k]` at the next clock edge, and the flag then stays set with no further event. The bit meanings are: 6 receive warning, 5 transmit warning, 4 receive error-passive, 3 transmit error-passive, 2 bus-off, 1 overrun, 0 receive buffer full.
- R3: `flagRd[7]` (wake-up) is set at the next edge only when `sleepMode` and `busActivity` are both high. Bus activity outside sleep mode leaves it at 0.
- R4: A cycle with `wrFlagEn` high clears each flag whose `wrData` bit is 1 and whose cause is inactive. A `wrData` bit of 0 leaves its flag unchanged.
- R5: While a flag's cause is active, a write of one to that flag is ignored and the flag stays set. The cause is `causeIn[k]` for bits 0..6, and `sleepMode && busActivity` for bit 7.
- R6: If a set event and an accepted clear hit the same flag in the same cycle, the flag is set after the edge.
- R7: `softReset` high clears all flags at the next edge, even if set events arrive in the same cycle. The enable register keeps its value.
- R8: A cycle with `wrEnableEn` high loads `wrData` into `enableRd`. `irqReq` is high exactly when `flagRd & enableRd` is non-zero, so a flag keeps the request pending for as long as it stays set and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| softReset | input | 1 | Synchronous soft reset of the flags |
| sleepMode | input | 1 | Controller is in sleep mode |
| busActivity | input | 1 | Activity seen on the bus |
| eventIn | input | 7 | Set pulses for flags 0..6 |
| causeIn | input | 7 | Cause-still-present levels for flags 0..6 |
| wrFlagEn | input | 1 | Write-one-to-clear strobe for the flag register |
| wrEnableEn | input | 1 | Write strobe for the enable register |
| wrData | input | 8 | Write data |
| flagRd | output | 8 | Current flag values |
| enableRd | output | 8 | Current enable values |
| irqReq | output | 1 | Interrupt request |

## Verification
A hardware set event and a software clear write can land on the same flag in the same cycle. A soft reset can also coincide with set events. The bench provokes both cases by driving the event pulse together with the write or reset strobe on one falling edge. It then judges the flag register after the following rising edge: the set must win over the clear, and the soft reset must win over the set. It also holds a cause level high across a clear write and checks that the flag survives the write.

// File: rtl/rsfPkg.sv
package rsfPkg;
  localparam int FLAG_W   = 8;
  localparam int EVT_W    = FLAG_W - 1;
  localparam int WAKE_BIT = FLAG_W - 1;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic              clearAll;
    logic              enLoad;
  } flagStrobe_t;
endpackage

// File: rtl/rsfCtrl.sv
module rsfCtrl
  import rsfPkg::*;
(
  input  logic              softReset,
  input  logic              sleepMode,
  input  logic              busActivity,
  input  logic [EVT_W-1:0]  eventIn,
  input  logic [EVT_W-1:0]  causeIn,
  input  logic              wrFlagEn,
  input  logic              wrEnableEn,
  input  logic [FLAG_W-1:0] wrData,
  output flagStrobe_t       strb,
  output logic [FLAG_W-1:0] guardVec
);
  logic wakeCause;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;

  assign wakeCause = sleepMode & busActivity;

  for (genvar k = 0; k < FLAG_W; k++) begin : g_bit
    if (k == WAKE_BIT) begin : g_wake
      assign setVec[k]   = wakeCause;
      assign guardVec[k] = wakeCause;
    end else begin : g_evt
      assign setVec[k]   = eventIn[k];
      assign guardVec[k] = causeIn[k];
    end
    // a one clears only while the cause is gone; a zero never clears
    assign clrVec[k] = wrFlagEn & wrData[k] & ~guardVec[k];
  end

  always_comb begin
    strb.setMask  = setVec;
    strb.clrMask  = clrVec;
    strb.clearAll = softReset;
    strb.enLoad   = wrEnableEn;
  end
endmodule

// File: rtl/rsfDatapath.sv
module rsfDatapath
  import rsfPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strb,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] flagQ,
  output logic [FLAG_W-1:0] enableQ,
  output logic              irqReq
);
  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 flagQ[k] <= 1'b0;
      else if (strb.clearAll)    flagQ[k] <= 1'b0;
      else if (strb.setMask[k])  flagQ[k] <= 1'b1;
      else if (strb.clrMask[k])  flagQ[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enableQ <= '0;
    else if (strb.enLoad) enableQ <= wrData;
  end

  assign irqReq = |(flagQ & enableQ);

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAll |=> ((flagQ & $past(strb.setMask)) == $past(strb.setMask)));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAll |=> ((flagQ & ~$past(flagQ) & ~$past(strb.setMask)) == '0));

  assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearAll && ((strb.setMask & strb.clrMask) != '0)) |=>
      ((flagQ & $past(strb.setMask & strb.clrMask)) == $past(strb.setMask & strb.clrMask)));

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (flagQ == '0));

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.enLoad |=> $stable(enableQ));
endmodule

// File: rtl/rxStatusFlags.sv
module rxStatusFlags
  import rsfPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic              sleepMode,
  input  logic              busActivity,
  input  logic [EVT_W-1:0]  eventIn,
  input  logic [EVT_W-1:0]  causeIn,
  input  logic              wrFlagEn,
  input  logic              wrEnableEn,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] flagRd,
  output logic [FLAG_W-1:0] enableRd,
  output logic              irqReq
);
  flagStrobe_t       strb;
  logic [FLAG_W-1:0] guardVec;

  rsfCtrl u_ctrl (
    .softReset  (softReset),
    .sleepMode  (sleepMode),
    .busActivity(busActivity),
    .eventIn    (eventIn),
    .causeIn    (causeIn),
    .wrFlagEn   (wrFlagEn),
    .wrEnableEn (wrEnableEn),
    .wrData     (wrData),
    .strb       (strb),
    .guardVec   (guardVec)
  );

  rsfDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .flagQ  (flagRd),
    .enableQ(enableRd),
    .irqReq (irqReq)
  );

  assert_clear_guard_R5: assert property (@(posedge clk) disable iff (!rstN)
    !softReset |=> ((flagRd & $past(guardVec & flagRd)) == $past(guardVec & flagRd)));

  assert_wake_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(flagRd[WAKE_BIT]) && flagRd[WAKE_BIT]) |-> $past(sleepMode && busActivity));
endmodule

// File: tb/rxStatusFlags_bench.sv
module rxStatusFlags_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       softReset, sleepMode, busActivity;
  logic [6:0] eventIn, causeIn;
  logic       wrFlagEn, wrEnableEn;
  logic [7:0] wrData;
  logic [7:0] flagRd, enableRd;
  logic       irqReq;
  int         errors = 0;
  int         checks = 0;

  always #5 clk = ~clk;

  rxStatusFlags u_rxStatusFlags (
    .clk(clk), .rstN(rstN), .softReset(softReset), .sleepMode(sleepMode),
    .busActivity(busActivity), .eventIn(eventIn), .causeIn(causeIn),
    .wrFlagEn(wrFlagEn), .wrEnableEn(wrEnableEn), .wrData(wrData),
    .flagRd(flagRd), .enableRd(enableRd), .irqReq(irqReq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // drive strobes on a falling edge, let one rising edge pass, drop the strobes
  task automatic step(input logic [6:0] ev, input logic wf, input logic we,
                      input logic [7:0] d, input logic sr);
    eventIn = ev; wrFlagEn = wf; wrEnableEn = we; wrData = d; softReset = sr;
    @(negedge clk);
    eventIn = '0; wrFlagEn = 1'b0; wrEnableEn = 1'b0; wrData = '0; softReset = 1'b0;
  endtask

  task automatic testReset;
    check("R1 flags in reset", flagRd, 8'h00);
    check("R1 enables in reset", enableRd, 8'h00);
    check("R1 irq in reset", {7'd0, irqReq}, 8'h00);
  endtask

  task automatic testSetEach;
    logic [7:0] expv = 8'h00;
    for (int k = 0; k < 7; k++) begin
      step(7'(1 << k), 1'b0, 1'b0, 8'h00, 1'b0);
      expv[k] = 1'b1;
      check("R2 event sets flag", flagRd, expv);
    end
    step(7'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R2 flags sticky", flagRd, 8'h7F);
    step(7'h00, 1'b1, 1'b0, 8'hFF, 1'b0);
    check("R4 clear all", flagRd, 8'h00);
  endtask

  task automatic testWake;
    busActivity = 1'b1; sleepMode = 1'b0;
    step(7'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R3 activity awake no wake flag", flagRd, 8'h00);
    sleepMode = 1'b1;
    step(7'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R3 activity in sleep sets wake", flagRd, 8'h80);
    step(7'h00, 1'b1, 1'b0, 8'h80, 1'b0);
    check("R5 wake clear refused", flagRd, 8'h80);
    busActivity = 1'b0;
    step(7'h00, 1'b1, 1'b0, 8'h80, 1'b0);
    check("R4 wake cleared", flagRd, 8'h00);
    sleepMode = 1'b0;
  endtask

  task automatic testGuard;
    causeIn = 7'h04;
    step(7'h04, 1'b0, 1'b0, 8'h00, 1'b0);
    step(7'h00, 1'b1, 1'b0, 8'h04, 1'b0);
    check("R5 bus-off clear refused", flagRd, 8'h04);
    causeIn = 7'h00;
    step(7'h00, 1'b1, 1'b0, 8'h04, 1'b0);
    check("R4 bus-off cleared", flagRd, 8'h00);
    step(7'h02, 1'b0, 1'b0, 8'h00, 1'b0);
    step(7'h00, 1'b1, 1'b0, 8'h00, 1'b0);
    check("R4 zero write no effect", flagRd, 8'h02);
    step(7'h00, 1'b1, 1'b0, 8'hFD, 1'b0);
    check("R4 other bits no effect", flagRd, 8'h02);
    step(7'h00, 1'b1, 1'b0, 8'h02, 1'b0);
    check("R4 overrun cleared", flagRd, 8'h00);
  endtask

  task automatic testSetVsClear;
    step(7'h01, 1'b0, 1'b0, 8'h00, 1'b0);
    step(7'h01, 1'b1, 1'b0, 8'h01, 1'b0);
    check("R6 set beats clear", flagRd, 8'h01);
    step(7'h00, 1'b1, 1'b0, 8'h01, 1'b0);
    check("R6 later clear accepted", flagRd, 8'h00);
  endtask

  task automatic testSoftReset;
    step(7'h00, 1'b0, 1'b1, 8'h55, 1'b0);
    step(7'h7F, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R7 flags before soft reset", flagRd, 8'h7F);
    step(7'h7F, 1'b0, 1'b0, 8'h00, 1'b1);
    check("R7 soft reset beats set", flagRd, 8'h00);
    check("R7 enables kept", enableRd, 8'h55);
  endtask

  task automatic testIrq;
    step(7'h00, 1'b0, 1'b1, 8'h00, 1'b0);
    step(7'h08, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R8 masked flag no irq", {7'd0, irqReq}, 8'h00);
    step(7'h00, 1'b0, 1'b1, 8'h08, 1'b0);
    check("R8 enable loaded", enableRd, 8'h08);
    check("R8 enabled flag irq", {7'd0, irqReq}, 8'h01);
    step(7'h00, 1'b0, 1'b1, 8'h81, 1'b0);
    check("R8 other enable no irq", {7'd0, irqReq}, 8'h00);
    sleepMode = 1'b1; busActivity = 1'b1;
    step(7'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    busActivity = 1'b0;
    step(7'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R8 wake irq pending", {7'd0, irqReq}, 8'h01);
    step(7'h00, 1'b1, 1'b0, 8'h80, 1'b0);
    check("R8 wake irq gone after clear", {7'd0, irqReq}, 8'h00);
    sleepMode = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; softReset = 1'b0; sleepMode = 1'b0; busActivity = 1'b0;
    eventIn = '0; causeIn = '0; wrFlagEn = 1'b0; wrEnableEn = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testSetEach();
    testWake();
    testGuard();
    testSetVsClear();
    testSoftReset();
    testIrq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule